// File: doc/BRIEF.md
# Multi-Port Interrupt Status and Enable Unit

This block collects interrupt events for a small group of storage link ports. Each port has twelve event sources. A one-cycle pulse on a source latches a raw status bit. The raw bit is combined with a per-port enable vector to form a masked view, and the port's interrupt line is raised while any masked bit is set.

Software reads both views through one status word: masked bits sit in the low field and raw bits sit from bit 16 upward. It clears latched events by writing ones to that word. The enable vector is never written directly. One address sets enable bits and another clears them. Bits 31:30 of both writes also set or clear a two-bit steering field, which is stored per port and driven out to the interrupt routing logic.

Each port has a mode bit that governs its completion event (bit 0). With the mode bit off, reading the completion register acknowledges the event and clears it. With the mode bit on, the read leaves it set, and only a write of one to the status word clears it. The per-port interrupt lines are collected into a global summary register. A global enable register gates them onto the single host interrupt output.

Top module: `port_irq_hub`

## Requirements
- R1: After reset, all raw status bits, enable bits, steering fields, mode bits and the global enable are zero, and `irq_o` and every `port_irq_o` bit are low.
- R2: A high pulse on source i of port p sets raw bit i of that port on the next clock edge, whatever the enable state. The raw bit reads back at bit 16+i of the status word (register code 0).
- R3: Bits 11:0 of the status word show raw AND enable. All other bits outside the two fields read zero.
- R4: A write to the enable-set register (code 1) ORs wdata[11:0] into the port's enables. Reading code 1 or code 2 returns the enables in bits 11:0 and the steering field in bits 31:30.
- R5: A write to the enable-clear register (code 2) clears every enable whose wdata bit is one. Writing 0x0000FFFF masks all sources and leaves the steering field unchanged.
- R6: The steering field is set where bits 31:30 of an enable-set write are one and cleared where bits 31:30 of an enable-clear write are one. It appears on `steer_o[2p+1:2p]`. Other accesses leave it unchanged.
- R7: Writing the status word clears the raw bits whose wdata[11:0] bit is one and leaves all others unchanged.
- R8: A source pulse in the same cycle as a write that clears its raw bit leaves the bit set.
- R9: The mode bit is bit 0 of register code 3, read and write. Reading code 4 returns the raw completion bit in bit 0. With the mode bit at 0, that read (rd_en high) clears completion. With the mode bit at 1, it does not. A status write clears completion in either mode.
- R10: `port_irq_o[p]` is high exactly when port p has a bit set in both raw status and enables. Register code 5 returns these lines in bits 3:0, and port_sel is ignored.
- R11: Register code 6 holds the global enable in bits 3:0 (writing 0xF enables all ports). `irq_o` is the OR of the port lines ANDed with this enable.
- R12: Port registers accessed with one port_sel value leave every other port's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | NPORTS*NUM_SRC | Event pulses, port p at bits [p*NUM_SRC +: NUM_SRC] |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (only side effect: completion acknowledge) |
| port_sel | input | PSEL_W | Port addressed by per-port registers |
| reg_sel | input | 3 | Register code |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register, combinational |
| steer_o | output | NPORTS*2 | Per-port steering fields |
| port_irq_o | output | NPORTS | Per-port interrupt lines |
| irq_o | output | 1 | Host interrupt |

## Verification
Two functions can meet in one cycle. An event can arrive while a status write or a completion-acknowledge read clears the same bit. The bench provokes this by driving the event pulse and the clearing access on the same clock edge. It passes only if the bit reads back set afterwards, while other bits in the same clear mask do drop. Completion acknowledge is also checked against the mode bit: the read data must show the bit during the read, and the bit must clear afterwards only when the mode bit is off.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  localparam int DATA_W    = 32;
  localparam int RAW_LSB   = 16;
  localparam int STEER_LSB = 30;
  localparam int STEER_W   = 2;
  localparam int CMPL_BIT  = 0;

  typedef enum logic [2:0] {
    RG_STATUS = 3'd0,
    RG_EN_SET = 3'd1,
    RG_EN_CLR = 3'd2,
    RG_CFG    = 3'd3,
    RG_DONE   = 3'd4,
    RG_GSTAT  = 3'd5,
    RG_GEN    = 3'd6,
    RG_NONE   = 3'd7
  } reg_code_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irq_port_slice.sv
module irq_port_slice
  import port_irq_pkg::*;
#(
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               wr_stat,
  input  logic               wr_set,
  input  logic               wr_clr,
  input  logic               wr_cfg,
  input  logic               rd_done,
  input  logic [NUM_SRC-1:0] wd_src,
  input  logic [STEER_W-1:0] wd_steer,
  input  logic               wd_mode,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [STEER_W-1:0] steer_o,
  output logic               mode_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] raw_q, raw_d, en_q, en_d, clr_mask;
  logic [STEER_W-1:0] steer_q, steer_d;
  logic               mode_q, mode_d;
  logic               raw_ce, en_ce, mode_ce;

  // Next state: clears applied first, then new events, so an event wins.
  always_comb begin
    clr_mask = wr_stat ? wd_src : '0;
    if (rd_done && !mode_q) clr_mask[CMPL_BIT] = 1'b1;
    raw_d  = (raw_q & ~clr_mask) | evt;
    raw_ce = wr_stat | rd_done | (|evt);

    en_d    = en_q;
    steer_d = steer_q;
    if (wr_set) begin
      en_d    = en_q | wd_src;
      steer_d = steer_q | wd_steer;
    end else if (wr_clr) begin
      en_d    = en_q & ~wd_src;
      steer_d = steer_q & ~wd_steer;
    end
    en_ce = wr_set | wr_clr;

    mode_d  = wd_mode;
    mode_ce = wr_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      en_q    <= '0;
      steer_q <= '0;
      mode_q  <= 1'b0;
    end else begin
      if (raw_ce)  raw_q <= raw_d;
      if (en_ce) begin
        en_q    <= en_d;
        steer_q <= steer_d;
      end
      if (mode_ce) mode_q <= mode_d;
    end
  end

  assign raw_o   = raw_q;
  assign en_o    = en_q;
  assign steer_o = steer_q;
  assign mode_o  = mode_q;
  assign irq_o   = |(raw_q & en_q);
endmodule

// File: rtl/irq_global_summary.sv
module irq_global_summary #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_gen,
  input  logic [NPORTS-1:0] wd_gen,
  input  logic [NPORTS-1:0] port_irq,
  output logic [NPORTS-1:0] gen_o,
  output logic              irq_o
);
  logic [NPORTS-1:0] gen_q, gen_d;
  logic              gen_ce;

  always_comb begin
    gen_d  = wd_gen;
    gen_ce = wr_gen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gen_q <= '0;
    else if (gen_ce) gen_q <= gen_d;
  end

  assign gen_o = gen_q;
  assign irq_o = |(port_irq & gen_q);
endmodule

// File: rtl/port_irq_hub.sv
module port_irq_hub
  import port_irq_pkg::*;
#(
  parameter int NPORTS  = 4,
  parameter int NUM_SRC = 12,
  localparam int PSEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPORTS*NUM_SRC-1:0]   evt_i,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [PSEL_W-1:0]           port_sel,
  input  logic [2:0]                  reg_sel,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [NPORTS*STEER_W-1:0]   steer_o,
  output logic [NPORTS-1:0]           port_irq_o,
  output logic                        irq_o
);
  logic                       rst_s_n;
  reg_code_e                  code;
  logic                       port_ok;
  logic [NPORTS*NUM_SRC-1:0]  raw_flat, en_flat;
  logic [NPORTS-1:0]          mode_flat, gen;
  logic [NUM_SRC-1:0]         raw_sel, en_sel;
  logic [STEER_W-1:0]         steer_sel;
  logic                       mode_sel;
  logic                       unused_wdata;

  assign code         = reg_code_e'(reg_sel);
  assign port_ok      = (int'(port_sel) < NPORTS);
  assign unused_wdata = ^wdata;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic hit;
    assign hit = (port_sel == PSEL_W'(p));

    irq_port_slice #(.NUM_SRC(NUM_SRC)) u_slice (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .evt      (evt_i[p*NUM_SRC +: NUM_SRC]),
      .wr_stat  (wr_en && hit && code == RG_STATUS),
      .wr_set   (wr_en && hit && code == RG_EN_SET),
      .wr_clr   (wr_en && hit && code == RG_EN_CLR),
      .wr_cfg   (wr_en && hit && code == RG_CFG),
      .rd_done  (rd_en && hit && code == RG_DONE),
      .wd_src   (wdata[NUM_SRC-1:0]),
      .wd_steer (wdata[STEER_LSB +: STEER_W]),
      .wd_mode  (wdata[0]),
      .raw_o    (raw_flat[p*NUM_SRC +: NUM_SRC]),
      .en_o     (en_flat[p*NUM_SRC +: NUM_SRC]),
      .steer_o  (steer_o[p*STEER_W +: STEER_W]),
      .mode_o   (mode_flat[p]),
      .irq_o    (port_irq_o[p])
    );
  end

  irq_global_summary #(.NPORTS(NPORTS)) u_sum (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_gen   (wr_en && code == RG_GEN),
    .wd_gen   (wdata[NPORTS-1:0]),
    .port_irq (port_irq_o),
    .gen_o    (gen),
    .irq_o    (irq_o)
  );

  // Read path: pick the addressed port's state, then format by register code.
  always_comb begin
    raw_sel   = '0;
    en_sel    = '0;
    steer_sel = '0;
    mode_sel  = 1'b0;
    if (port_ok) begin
      raw_sel   = raw_flat[int'(port_sel)*NUM_SRC +: NUM_SRC];
      en_sel    = en_flat[int'(port_sel)*NUM_SRC +: NUM_SRC];
      steer_sel = steer_o[int'(port_sel)*STEER_W +: STEER_W];
      mode_sel  = mode_flat[int'(port_sel)];
    end
    rdata = '0;
    unique case (code)
      RG_STATUS: begin
        rdata[NUM_SRC-1:0]         = raw_sel & en_sel;
        rdata[RAW_LSB +: NUM_SRC]  = raw_sel;
      end
      RG_EN_SET, RG_EN_CLR: begin
        rdata[NUM_SRC-1:0]         = en_sel;
        rdata[STEER_LSB +: STEER_W] = steer_sel;
      end
      RG_CFG:   rdata[0]            = mode_sel;
      RG_DONE:  rdata[0]            = raw_sel[CMPL_BIT];
      RG_GSTAT: rdata[NPORTS-1:0]   = port_irq_o;
      RG_GEN:   rdata[NPORTS-1:0]   = gen;
      default:  rdata               = '0;
    endcase
  end
endmodule

// File: rtl/port_irq_checker.sv
module port_irq_checker
  import port_irq_pkg::*;
#(
  parameter int NPORTS  = 4,
  parameter int NUM_SRC = 12,
  parameter int PSEL_W  = 2
) (
  input logic                       clk,
  input logic                       rst_s_n,
  input logic [NPORTS*NUM_SRC-1:0]  evt_i,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic [PSEL_W-1:0]          port_sel,
  input logic [2:0]                 reg_sel,
  input logic [DATA_W-1:0]          wdata,
  input logic [NPORTS*NUM_SRC-1:0]  raw_flat,
  input logic [NPORTS*NUM_SRC-1:0]  en_flat,
  input logic [NPORTS-1:0]          mode_flat,
  input logic [NPORTS-1:0]          gen,
  input logic [NPORTS*STEER_W-1:0]  steer_o,
  input logic [NPORTS-1:0]          port_irq_o,
  input logic                       irq_o
);
  logic ok;
  assign ok = (int'(port_sel) < NPORTS);

  p_evt_latch_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    1'b1 |=> ((raw_flat & $past(evt_i)) == $past(evt_i)));

  p_no_spont_set_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    1'b1 |=> ((raw_flat & ~$past(raw_flat) & ~$past(evt_i)) == '0));

  p_mask_all_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && reg_sel == RG_EN_CLR && ok && wdata[NUM_SRC-1:0] == '1)
    |=> (en_flat[int'($past(port_sel))*NUM_SRC +: NUM_SRC] == '0));

  p_keep_done_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_en && !wr_en && reg_sel == RG_DONE && ok && mode_flat[int'(port_sel)]
     && raw_flat[int'(port_sel)*NUM_SRC])
    |=> raw_flat[int'($past(port_sel))*NUM_SRC]);

  p_steer_hold_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wr_en |=> $stable(steer_o));

  p_line_masked_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en_flat == '0) |-> (port_irq_o == '0));

  p_host_gate_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (gen == '0) |-> !irq_o);
endmodule

bind port_irq_hub port_irq_checker #(
  .NPORTS(NPORTS), .NUM_SRC(NUM_SRC), .PSEL_W(PSEL_W)
) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
  .port_sel(port_sel), .reg_sel(reg_sel), .wdata(wdata), .raw_flat(raw_flat),
  .en_flat(en_flat), .mode_flat(mode_flat), .gen(gen), .steer_o(steer_o),
  .port_irq_o(port_irq_o), .irq_o(irq_o)
);

// File: tb/test_port_irq_hub.sv
module test_port_irq_hub;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NS = 12;
  localparam logic [2:0] C_STAT = 3'd0, C_SET = 3'd1, C_CLR = 3'd2,
                         C_CFG = 3'd3, C_DONE = 3'd4, C_GSTAT = 3'd5, C_GEN = 3'd6;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst_n;
  logic [NP*NS-1:0]  evt;
  logic              wr_en, rd_en;
  logic [1:0]        port_sel;
  logic [2:0]        reg_sel;
  logic [31:0]       wdata, rdata;
  logic [NP*2-1:0]   steer_o;
  logic [NP-1:0]     port_irq_o;
  logic              irq_o;

  port_irq_hub #(.NPORTS(NP), .NUM_SRC(NS)) i_port_irq_hub (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en(wr_en), .rd_en(rd_en),
    .port_sel(port_sel), .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
    .steer_o(steer_o), .port_irq_o(port_irq_o), .irq_o(irq_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [NS-1:0] m_raw [NP];
  logic [NS-1:0] m_en  [NP];
  logic [1:0]    m_st  [NP];
  logic          m_mode[NP];
  logic [NP-1:0] m_gen;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic peek(int p, logic [2:0] r, output logic [31:0] d);
    port_sel = p[1:0];
    reg_sel  = r;
    #1;
    d = rdata;
  endtask

  // One bus cycle; model updated from the requirements afterwards.
  task automatic bus(int p, logic [2:0] r, logic [31:0] d, bit w, bit rd,
                     logic [NP*NS-1:0] ev, output logic [31:0] rd_data);
    @(negedge clk);
    port_sel = p[1:0]; reg_sel = r; wdata = d; wr_en = w; rd_en = rd; evt = ev;
    #1;
    rd_data = rdata;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; evt = '0;
    for (int q = 0; q < NP; q++) begin
      logic [NS-1:0] clr;
      clr = '0;
      if (w && q == p && r == C_STAT) clr = d[NS-1:0];
      if (rd && q == p && r == C_DONE && !m_mode[q]) clr[0] = 1'b1;
      m_raw[q] = (m_raw[q] & ~clr) | ev[q*NS +: NS];
      if (w && q == p && r == C_SET) begin
        m_en[q] = m_en[q] | d[NS-1:0];
        m_st[q] = m_st[q] | d[31:30];
      end
      if (w && q == p && r == C_CLR) begin
        m_en[q] = m_en[q] & ~d[NS-1:0];
        m_st[q] = m_st[q] & ~d[31:30];
      end
      if (w && q == p && r == C_CFG) m_mode[q] = d[0];
    end
    if (w && r == C_GEN) m_gen = d[NP-1:0];
  endtask

  task automatic wr(int p, logic [2:0] r, logic [31:0] d);
    logic [31:0] junk;
    bus(p, r, d, 1'b1, 1'b0, '0, junk);
  endtask

  task automatic fire(int p, int i);
    logic [NP*NS-1:0] ev;
    logic [31:0] junk;
    ev = '0;
    ev[p*NS + i] = 1'b1;
    bus(p, C_STAT, 32'h0, 1'b0, 1'b0, ev, junk);
  endtask

  // Compare every register of every port against the model.
  task automatic verify(string ctx);
    logic [31:0] d;
    logic [NP-1:0] lines;
    lines = '0;
    for (int q = 0; q < NP; q++) begin
      lines[q] = |(m_raw[q] & m_en[q]);
      peek(q, C_STAT, d);
      chk("R3", {ctx, " status"}, d, (32'(m_raw[q]) << 16) | 32'(m_raw[q] & m_en[q]));
      peek(q, C_SET, d);
      chk("R4", {ctx, " enable"}, d, 32'(m_en[q]) | (32'(m_st[q]) << 30));
      peek(q, C_CFG, d);
      chk("R9", {ctx, " mode"}, d, 32'(m_mode[q]));
      chk("R6", {ctx, " steer_o"}, 32'(steer_o[q*2 +: 2]), 32'(m_st[q]));
    end
    peek(3, C_GSTAT, d);
    chk("R10", {ctx, " summary"}, d, 32'(lines));
    chk("R10", {ctx, " port_irq_o"}, 32'(port_irq_o), 32'(lines));
    peek(0, C_GEN, d);
    chk("R11", {ctx, " global enable"}, d, 32'(m_gen));
    chk("R11", {ctx, " irq_o"}, 32'(irq_o), 32'(|(lines & m_gen)));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; evt = '0;
    port_sel = '0; reg_sel = '0; wdata = '0;
    for (int q = 0; q < NP; q++) begin
      m_raw[q] = '0; m_en[q] = '0; m_st[q] = '0; m_mode[q] = 1'b0;
    end
    m_gen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", "irq_o after reset", 32'(irq_o), 32'h0);
    verify("R1");

    // R2: every source of every port latches, enables still off
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < NS; i++) begin
        fire(p, i);
        peek(p, C_STAT, d);
        chk("R2", $sformatf("raw p%0d b%0d", p, i), d & (32'h1 << (16 + i)), 32'h1 << (16 + i));
      end
    verify("R2");

    // R4, R6, R12: per-port enable and steering patterns
    for (int p = 0; p < NP; p++) begin
      wr(p, C_SET, {p[1:0] + 2'd1, 18'h0, 12'h5A5 ^ (12'h111 << p)});
      verify("R12 set");
    end

    // R11: global enable patterns
    for (int g = 0; g < 16; g += 5) begin
      wr(1, C_GEN, 32'(g));
      verify("R11 gen");
    end
    wr(0, C_GEN, 32'hF);

    // R7: walking clears on port 2, then all of port 3
    for (int i = 0; i < NS; i++) begin
      wr(2, C_STAT, 32'h1 << i);
      verify("R7 walk");
    end
    wr(3, C_STAT, 32'h0000_0FFF);
    verify("R7 all");

    // R8: event collides with clear of the same bit
    begin
      logic [NP*NS-1:0] ev;
      ev = '0; ev[1*NS + 3] = 1'b1;
      bus(1, C_STAT, 32'h0000_0018, 1'b1, 1'b0, ev, d);
      peek(1, C_STAT, d);
      chk("R8", "bit3 kept, bit4 cleared", d & 32'h0018_0000, 32'h0008_0000);
      verify("R8");
    end

    // R9: completion acknowledge with mode off, then on
    fire(2, 0);
    bus(2, C_DONE, 32'h0, 1'b0, 1'b1, '0, d);
    chk("R9", "done read data", d, 32'h1);
    peek(2, C_DONE, d);
    chk("R9", "cleared by read, mode off", d, 32'h0);
    wr(2, C_CFG, 32'h1);
    fire(2, 0);
    bus(2, C_DONE, 32'h0, 1'b0, 1'b1, '0, d);
    peek(2, C_DONE, d);
    chk("R9", "kept by read, mode on", d, 32'h1);
    wr(2, C_STAT, 32'h1);
    peek(2, C_DONE, d);
    chk("R9", "cleared by write, mode on", d, 32'h0);
    verify("R9");

    // R5: mask every source on port 0, steering kept
    wr(0, C_CLR, 32'h0000_FFFF);
    peek(0, C_CLR, d);
    chk("R5", "enables cleared, steer kept", d, 32'h4000_0000);
    verify("R5");

    // R6: clear one steering bit through the clear address
    wr(3, C_CLR, 32'h4000_0000);
    chk("R6", "steer p3", 32'(steer_o[7:6]), 32'h0);
    verify("R6");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule